// File: doc/BRIEF.md
# Inline Line Deduplication Detector

This block sits on the write path of a memory controller and decides, before a 64-byte line reaches memory, whether the same content is already stored at some other line address. It fingerprints the incoming line with a CRC-32, looks the fingerprint up in a small direct-mapped table of fingerprints and line addresses, and on a match fetches the candidate line from memory and compares all of its bytes with the new line. Only a full byte match is reported as a duplicate. The controller then drops that write and records the matching address. Any other outcome is reported as unique, and the write goes ahead.

The CRC is only a filter. A matching fingerprint costs one memory read, and a confirmed duplicate saves one memory write. A line whose fingerprint is absent from the table is declared unique with no memory traffic at all. The detector handles one line at a time. It holds its input ready low from acceptance until the verdict pulse.

Top module: `line_dedup_detector`

## Requirements
- R1: A line is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only when the block is idle, and stays low from the acceptance edge until the edge that starts the verdict pulse.
- R2: The fingerprint is a CRC-32 with generator 0x04C11DB7, start value 0xFFFFFFFF and final inversion 0xFFFFFFFF, computed without bit reflection. Byte k of the line is `wr_data[8k+7:8k]`. Bytes are fed in ascending k, each byte most significant bit first, eight bytes per clock.
- R3: The table has 64 direct-mapped entries selected by CRC bits [5:0]. Each entry holds a valid flag, the full 32-bit CRC and a line address. A lookup counts as a hit only if the entry is valid and its full CRC equals the new CRC.
- R4: On a lookup miss the verdict is unique, no read request is issued, and `vd_valid` rises at the 9th rising edge after the acceptance edge.
- R5: On a hit, exactly one read request is issued, with `rd_req_addr` equal to the stored address, as a one-cycle pulse starting at the 9th edge after acceptance. The verdict starts at the edge that samples `rd_resp_valid` high. `rd_resp_valid` is ignored outside that wait.
- R6: A duplicate (`vd_dup`=1) is declared only when all 64 bytes of the read data equal the new line. `vd_match_addr` then carries the stored address.
- R7: A hit whose byte comparison fails is reported unique, and the entry is replaced by the new line's CRC and address.
- R8: A miss inserts the new line's CRC and address, replacing whatever entry occupied that index.
- R9: A confirmed duplicate leaves the table unchanged.
- R10: After synchronous reset every table entry is invalid, `wr_ready` is high, and `vd_valid` and `rd_req_valid` are low.
- R11: `vd_valid` is a one-cycle pulse per accepted line. `vd_match_addr` is zero when the verdict is unique.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Incoming line is valid |
| wr_ready | output | 1 | Block is idle and can take a line |
| wr_addr | input | ADDR_W | Destination line address of the write |
| wr_data | input | 512 | Line content, byte k at bits 8k+7:8k |
| rd_req_valid | output | 1 | One-cycle read request for a candidate line |
| rd_req_addr | output | ADDR_W | Address of the candidate line |
| rd_resp_valid | input | 1 | Read data is present |
| rd_resp_data | input | 512 | Candidate line content |
| vd_valid | output | 1 | Verdict pulse |
| vd_dup | output | 1 | 1 = duplicate (drop write), 0 = unique |
| vd_match_addr | output | ADDR_W | Address of the matching stored line, zero if unique |

## Verification
The assertions assume that the memory returns exactly one response for each read request and never drives `rd_resp_valid` before the request pulse has been seen. They also assume that `wr_valid` is only raised while the block is idle. The bench follows both rules: it raises `wr_valid` for a single cycle, and it answers each request pulse with a single response a fixed three cycles later, taken from its own line store. Stale-memory cases are produced by altering that store between writes, not by sending stray responses.

// File: rtl/dedup_pkg.sv
package dedup_pkg;

    localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_XOROUT = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HASH,
        ST_RDREQ,
        ST_WAIT,
        ST_VERDICT
    } dd_state_e;

    typedef struct packed {
        logic        dup;
        logic [31:0] crc;
    } dd_result_s;

    // Advance a non-reflected CRC-32 by one byte, MSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[31] ^ b[i]) c = {c[30:0], 1'b0} ^ CRC_POLY;
            else              c = {c[30:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/dedup_crc_engine.sv
module dedup_crc_engine
    import dedup_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LINE_BYTES*8-1:0] line,
    output logic                    done,
    output logic [31:0]             crc
);
    localparam int NUM_BEATS = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W    = BEAT_BYTES * 8;
    localparam int CNT_W     = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(NUM_BEATS - 1);

    logic             busy_q;
    logic [CNT_W-1:0] beat_q;
    logic [31:0]      acc_q, acc_nxt;
    logic [BEAT_W-1:0] word;

    assign word = line[beat_q*BEAT_W +: BEAT_W];

    always_comb begin
        acc_nxt = acc_q;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            acc_nxt = crc_byte(acc_nxt, word[i*8 +: 8]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            acc_q  <= CRC_INIT;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                beat_q <= '0;
                acc_q  <= CRC_INIT;
            end else if (busy_q) begin
                acc_q <= acc_nxt;
                if (beat_q == LAST_BEAT) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    assign crc = acc_q ^ CRC_XOROUT;

    // R1: a new line never restarts a hash in progress
    p_no_restart_r1: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R2: completion comes only out of an active hash and ends it
    p_done_ends_hash_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy_q && $past(busy_q)));

endmodule

// File: rtl/dedup_hash_table.sv
module dedup_hash_table #(
    parameter int IDX_W  = 6,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [31:0]       rd_crc,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_crc,
    input  logic [ADDR_W-1:0] wr_addr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [31:0]       crc_mem  [DEPTH];
    logic [ADDR_W-1:0] addr_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)        valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            crc_mem[wr_idx]  <= wr_crc;
            addr_mem[wr_idx] <= wr_addr;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_crc   = crc_mem[rd_idx];
    assign rd_addr  = addr_mem[rd_idx];

    // R8: a written entry reads back valid with the written fields
    p_insert_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_idx == wr_idx) |=>
            ($past(rd_idx) != rd_idx) || (rd_valid && rd_crc == $past(wr_crc)));

    // R10: valid entries only grow while no reset is applied
    p_valid_monotonic_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(valid_q) >= $countones($past(valid_q)));

endmodule

// File: rtl/dedup_line_compare.sv
module dedup_line_compare #(
    parameter int LINE_BYTES = 64
) (
    input  logic [LINE_BYTES*8-1:0] line_a,
    input  logic [LINE_BYTES*8-1:0] line_b,
    output logic                    equal
);
    logic [LINE_BYTES-1:0] byte_eq;

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
        assign byte_eq[g] = (line_a[g*8 +: 8] == line_b[g*8 +: 8]);
    end

    assign equal = &byte_eq;

endmodule

// File: rtl/line_dedup_detector.sv
module line_dedup_detector
    import dedup_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int IDX_W      = 6,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LINE_BYTES*8-1:0] wr_data,
    output logic                    rd_req_valid,
    output logic [ADDR_W-1:0]       rd_req_addr,
    input  logic                    rd_resp_valid,
    input  logic [LINE_BYTES*8-1:0] rd_resp_data,
    output logic                    vd_valid,
    output logic                    vd_dup,
    output logic [ADDR_W-1:0]       vd_match_addr
);
    localparam int LINE_W = LINE_BYTES * 8;

    dd_state_e         state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] cand_q;
    logic [31:0]       crc_q;
    dd_result_s        res_q;
    logic [ADDR_W-1:0] match_q;
    logic              rd_issued_q;

    logic              fire;
    logic              crc_done;
    logic [31:0]       crc_val;
    logic              t_valid;
    logic [31:0]       t_crc;
    logic [ADDR_W-1:0] t_addr;
    logic              hit;
    logic              lines_eq;
    logic              resp_take;
    logic              t_we;
    logic [IDX_W-1:0]  t_widx;
    logic [31:0]       t_wcrc;

    assign fire      = wr_valid && wr_ready;
    assign hit       = crc_done && t_valid && (t_crc == crc_val);
    assign resp_take = (state_q == ST_WAIT) && rd_resp_valid;

    dedup_crc_engine #(
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES)
    ) crc_i (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .line  (line_q),
        .done  (crc_done),
        .crc   (crc_val)
    );

    dedup_hash_table #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) tbl_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (crc_val[IDX_W-1:0]),
        .rd_valid (t_valid),
        .rd_crc   (t_crc),
        .rd_addr  (t_addr),
        .wr_en    (t_we),
        .wr_idx   (t_widx),
        .wr_crc   (t_wcrc),
        .wr_addr  (addr_q)
    );

    dedup_line_compare #(
        .LINE_BYTES (LINE_BYTES)
    ) cmp_i (
        .line_a (line_q),
        .line_b (rd_resp_data),
        .equal  (lines_eq)
    );

    // Table update: insert on miss, replace on failed comparison
    always_comb begin
        t_we   = 1'b0;
        t_widx = crc_val[IDX_W-1:0];
        t_wcrc = crc_val;
        if (state_q == ST_HASH && crc_done && !hit) begin
            t_we = 1'b1;
        end else if (resp_take && !lines_eq) begin
            t_we   = 1'b1;
            t_widx = crc_q[IDX_W-1:0];
            t_wcrc = crc_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (fire) state_d = ST_HASH;
            ST_HASH:    if (crc_done) state_d = hit ? ST_RDREQ : ST_VERDICT;
            ST_RDREQ:   state_d = ST_WAIT;
            ST_WAIT:    if (rd_resp_valid) state_d = ST_VERDICT;
            ST_VERDICT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            line_q      <= '0;
            addr_q      <= '0;
            cand_q      <= '0;
            crc_q       <= '0;
            res_q       <= '0;
            match_q     <= '0;
            rd_issued_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                line_q      <= wr_data;
                addr_q      <= wr_addr;
                rd_issued_q <= 1'b0;
            end
            if (state_q == ST_HASH && crc_done) begin
                crc_q     <= crc_val;
                cand_q    <= t_addr;
                res_q.crc <= crc_val;
                res_q.dup <= 1'b0;
                match_q   <= '0;
            end
            if (state_q == ST_RDREQ) rd_issued_q <= 1'b1;
            if (resp_take) begin
                res_q.dup <= lines_eq;
                match_q   <= lines_eq ? cand_q : '0;
            end
        end
    end

    assign wr_ready      = (state_q == ST_IDLE);
    assign rd_req_valid  = (state_q == ST_RDREQ);
    assign rd_req_addr   = cand_q;
    assign vd_valid      = (state_q == ST_VERDICT);
    assign vd_dup        = res_q.dup;
    assign vd_match_addr = match_q;

    // R1: acceptance drops ready on the next cycle
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
        fire |=> !wr_ready);

    // R5: the read request is a single-cycle pulse
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |=> !rd_req_valid);

    // R6: a duplicate verdict is only given after a read went out
    p_dup_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
        (vd_valid && vd_dup) |-> rd_issued_q);

    // R9: a duplicate verdict is never accompanied by a table write in its deciding cycle
    p_dup_keeps_table_r9: assert property (@(posedge clk) disable iff (rst)
        (resp_take && lines_eq) |-> !t_we);

    // R11: verdict is a single-cycle pulse
    p_verdict_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        vd_valid |=> !vd_valid);

    // R11: unique verdicts carry a zero match address
    p_unique_zero_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (vd_valid && !vd_dup) |-> (vd_match_addr == '0));

endmodule

// File: tb/line_dedup_detector_tb_top.sv
module line_dedup_detector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int LINE_W     = 512;
    localparam int RESP_LAT   = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr;
    logic [LINE_W-1:0] wr_data;
    logic              rd_req_valid;
    logic [ADDR_W-1:0] rd_req_addr;
    logic              rd_resp_valid;
    logic [LINE_W-1:0] rd_resp_data;
    logic              vd_valid;
    logic              vd_dup;
    logic [ADDR_W-1:0] vd_match_addr;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // bench-side memory and table model
    logic [LINE_W-1:0] mem [256];
    logic              m_valid [64];
    logic [31:0]       m_crc   [64];
    logic [ADDR_W-1:0] m_addr  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_dedup_detector #(.ADDR_W(ADDR_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_req_valid  (rd_req_valid),
        .rd_req_addr   (rd_req_addr),
        .rd_resp_valid (rd_resp_valid),
        .rd_resp_data  (rd_resp_data),
        .vd_valid      (vd_valid),
        .vd_dup        (vd_dup),
        .vd_match_addr (vd_match_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Bit-serial reference CRC over the whole line
    function automatic logic [31:0] ref_crc(input logic [LINE_W-1:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < LINE_W; k++) begin
            logic bit_in;
            logic fb;
            bit_in = d[(k / 8) * 8 + (7 - (k % 8))];
            fb = c[31] ^ bit_in;
            c = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return ~c;
    endfunction

    function automatic logic [LINE_W-1:0] mk_line(input int seed);
        logic [LINE_W-1:0] d;
        for (int w = 0; w < 16; w++) begin
            d[w*32 +: 32] = (seed * 32'h9E3779B1) ^ (w * 32'h7F4A7C15) ^ (32'(seed) << w);
        end
        return d;
    endfunction

    task automatic do_write(input logic [LINE_W-1:0] data, input logic [ADDR_W-1:0] addr,
                            input string tag);
        logic [31:0]       c;
        int                idx;
        bit                exp_read;
        bit                exp_dup;
        logic [ADDR_W-1:0] exp_raddr;
        int                n;
        int                reads;
        int                resp_at;
        logic [ADDR_W-1:0] seen_raddr;
        bit                ready_ok;
        bit                got;
        int                vd_n;
        bit                dup_seen;
        logic [ADDR_W-1:0] match_seen;

        // expectation from the requirements
        c   = ref_crc(data);
        idx = int'(c[5:0]);
        exp_read  = m_valid[idx] && (m_crc[idx] == c);
        exp_raddr = m_addr[idx];
        exp_dup   = exp_read && (mem[exp_raddr[7:0]] == data);
        if (!exp_dup) begin
            m_valid[idx] = 1'b1;
            m_crc[idx]   = c;
            m_addr[idx]  = addr;
        end

        // drive
        wr_valid = 1'b1;
        wr_addr  = addr;
        wr_data  = data;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        n = 0; reads = 0; resp_at = -1; seen_raddr = '0; ready_ok = 1'b1;
        got = 1'b0; vd_n = 0; dup_seen = 1'b0; match_seen = '0;
        while (!got && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            rd_resp_valid = 1'b0;
            if (rd_req_valid) begin
                reads++;
                seen_raddr = rd_req_addr;
                resp_at = n + RESP_LAT;
            end
            if (n == resp_at) begin
                rd_resp_valid = 1'b1;
                rd_resp_data  = mem[seen_raddr[7:0]];
            end
            if (vd_valid) begin
                got = 1'b1;
                vd_n = n;
                dup_seen = vd_dup;
                match_seen = vd_match_addr;
            end else if (wr_ready) begin
                ready_ok = 1'b0;
            end
        end

        check(got, "R11", {tag, " verdict seen"}, longint'(got), 1);
        check(ready_ok, "R1", {tag, " ready low while busy"}, longint'(ready_ok), 1);
        check(dup_seen == exp_dup, exp_dup ? "R6" : "R7", {tag, " dup verdict"},
              longint'(dup_seen), longint'(exp_dup));
        check(match_seen == (exp_dup ? exp_raddr : '0), "R11", {tag, " match addr"},
              longint'(match_seen), longint'(exp_dup ? exp_raddr : '0));
        check(reads == (exp_read ? 1 : 0), exp_read ? "R5" : "R4", {tag, " read count"},
              longint'(reads), longint'(exp_read ? 1 : 0));
        if (exp_read) begin
            check(seen_raddr == exp_raddr, "R5", {tag, " read addr"},
                  longint'(seen_raddr), longint'(exp_raddr));
            check(vd_n == 9 + RESP_LAT + 1, "R5", {tag, " hit latency"},
                  longint'(vd_n), longint'(9 + RESP_LAT + 1));
        end else begin
            check(vd_n == 9, "R4", {tag, " miss latency"}, longint'(vd_n), 9);
        end
        // after the pulse the block is idle again and verdict is gone
        @(negedge clk);
        check(!vd_valid && wr_ready, "R11", {tag, " pulse ends"},
              longint'({vd_valid, wr_ready}), 1);
        if (!exp_dup) mem[addr[7:0]] = data;   // unique write proceeds
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [LINE_W-1:0] la, lb, lc, ld;
        logic [31:0]       ca;
        int                s2;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 1'b0; m_crc[i] = '0; m_addr[i] = '0;
        end
        rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        rd_resp_valid = 1'b0; rd_resp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check(wr_ready == 1'b1, "R10", "ready after reset", longint'(wr_ready), 1);
        check(vd_valid == 1'b0, "R10", "no verdict after reset", longint'(vd_valid), 0);
        check(rd_req_valid == 1'b0, "R10", "no read after reset", longint'(rd_req_valid), 0);

        // R2 R3 R4 R8: all-zero line into empty table is a miss and inserts
        do_write('0, 16'd1, "R2 zero line first");
        // R6: same line elsewhere confirms a duplicate
        do_write('0, 16'd2, "R6 zero line dup");

        la = mk_line(5);
        do_write(la, 16'd10, "R8 insert A");
        do_write(la, 16'd20, "R6 dup A");
        // R9: after a duplicate the entry still points to 10
        do_write(la, 16'd21, "R9 table unchanged");

        // R7: stale memory content makes the comparison fail
        lb = mk_line(77);
        do_write(lb, 16'd30, "R8 insert B");
        mem[30] = mk_line(78);
        do_write(lb, 16'd40, "R7 compare fails");
        do_write(lb, 16'd50, "R7 entry replaced");

        // R6: a single-byte difference is not a duplicate
        lc = mk_line(200);
        do_write(lc, 16'd60, "R8 insert C");
        mem[60] = lc ^ (512'hFF << 504);
        do_write(lc, 16'd61, "R6 top byte differs");

        // R3: same index, different full CRC is a miss with no read
        ld = mk_line(300);
        ca = ref_crc(ld);
        s2 = 301;
        while (ref_crc(mk_line(s2))[5:0] != ca[5:0] || ref_crc(mk_line(s2)) == ca) s2++;
        do_write(ld, 16'd70, "R3 first of pair");
        do_write(mk_line(s2), 16'd71, "R3 index conflict");
        do_write(ld, 16'd72, "R8 conflict evicted");

        // R5 R6 R7 R8 sweep over a small pool of contents and addresses
        for (int i = 0; i < 300; i++) begin
            do_write(mk_line(1000 + (i * 5) % 11), ADDR_W'((i * 37 + 3) % 256), "R5 R7 sweep");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule